// File: doc/BRIEF.md
# Memory Request Splitter and Bank/Row/Column Decoder

This block sits between an application port and a bank controller for a synchronous DRAM. The application presents one request at a time: a byte address, a length counted in memory words, a read/write flag and a wrap flag. The block turns the byte address into a memory-word address that matches the selected memory data width. It then breaks the word address into bank, row and column fields, using a column width chosen at run time.

When wrap is off, the block cuts the request into pieces so that no piece crosses the end of a column page. When wrap is on, the request goes out as one wrapped piece of four words. Each piece is offered downstream with a valid/ack handshake and carries first/final markers, the write flag and its own length. The application sees its acknowledge only when the downstream side accepts the final piece. An idle output tells the surrounding logic that no request is waiting and none is being split.

Top module: `splt_req_splitter`

## Requirements
- R1: While and right after reset (rst_n low at a clock edge), pc_valid and req_ack are 0 and idle is 1.
- R2: col_sel selects the column width: 0 gives 8 bits, 1 gives 9, 2 gives 10 and 3 gives 11. pc_col is the low column-width bits of the current word address, zero-extended to 12 bits.
- R3: The word address is the byte address shifted right by 2 when mem_width is 0 (32-bit memory), by 1 when it is 1 (16-bit memory), and not shifted when it is 2 or 3 (8-bit memory).
- R4: The bank sits directly above the column field. With NUM_BANKS=4 it takes two bits. With NUM_BANKS=2 it takes one bit and pc_bank[1] is 0.
- R5: pc_row is the 12 word-address bits directly above the bank field.
- R6: With wrap off, each piece's length is the smaller of the words still to send and the words left to the end of the current column page. The next piece starts at the word right after the previous piece, carrying into bank and row as needed.
- R7: With wrap on, exactly one piece is sent. It has length 4, both markers set, and the request's own column.
- R8: pc_start is 1 only on the first piece of a request and pc_last only on its final piece. pc_write and pc_wrap repeat the request's flags on every piece.
- R9: A piece offered with pc_valid stays unchanged until the cycle in which pc_ack is 1.
- R10: req_ack is 1 exactly in the cycle where the final piece is accepted (pc_valid, pc_ack and pc_last all 1), and at no other time.
- R11: idle is 1 when no request is held on req_valid and none is being split. Otherwise it is 0.
- R12: A request seen while idle produces its first piece on pc_valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| col_sel | input | 2 | Column width code (8 to 11 bits) |
| mem_width | input | 2 | Memory data width code (0: 32, 1: 16, 2/3: 8 bits) |
| req_valid | input | 1 | Application request present, held until req_ack |
| req_addr | input | AW (25) | Byte address |
| req_len | input | LW (12) | Length in memory words, at least 1 |
| req_wrap | input | 1 | Wrapped 4-word transfer |
| req_write | input | 1 | 1 for write, 0 for read |
| req_ack | output | 1 | Request completed downstream |
| pc_valid | output | 1 | Piece offered downstream |
| pc_bank | output | 2 | Bank number of the piece |
| pc_row | output | 12 | Row address of the piece |
| pc_col | output | 12 | Starting column of the piece |
| pc_len | output | LW (12) | Piece length in words |
| pc_write | output | 1 | Write flag of the piece |
| pc_wrap | output | 1 | Wrap flag of the piece |
| pc_start | output | 1 | First piece of a request |
| pc_last | output | 1 | Final piece of a request |
| pc_ack | input | 1 | Downstream accepts the current piece |
| idle | output | 1 | No request pending or in progress |

## Verification
The bench builds two copies side by side, driven by the same stimulus and the same acknowledge. One uses the defaults (AW=25, LW=12, NUM_BANKS=4). The other sets NUM_BANKS=2, which selects the one-bit bank branch of the decoder and shifts the row up by one bit. Both branches are therefore compared on every piece. The 12-bit length allows a single request to cross several 256-word pages and to fill an 11-bit page exactly. The acknowledge is stalled for zero to two cycles, so pieces are seen both held and taken at once.

// File: rtl/splt_pkg.sv
// Shared types and field widths for the request splitter.
package splt_pkg;
    localparam int ROW_W  = 12;   // row field width presented downstream
    localparam int COL_W  = 12;   // column field width presented downstream
    localparam int BANK_O = 2;    // bank port width
    localparam int WRAP_LEN = 4;  // words in a wrapped transfer

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SPLIT = 1'b1
    } split_state_e;
endpackage

// File: rtl/splt_addr_map.sv
// Address map: splits a word address into bank, row and column fields
// according to the run-time column width, and reports how many words
// remain before the end of the current column page.
// Assumes AW >= 14 so the column and bank fields always exist.
module splt_addr_map
    import splt_pkg::*;
#(
    parameter int AW        = 25,
    parameter int NUM_BANKS = 4
) (
    input  logic [AW-1:0]     waddr,
    input  logic [1:0]        col_sel,
    output logic [BANK_O-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic [COL_W-1:0]  room
);
    localparam int BANK_W = $clog2(NUM_BANKS);

    logic [3:0]    col_bits;
    logic [COL_W-1:0] col_mask;
    logic [AW-1:0] above_col;

    // Column field and words left to the page end.
    always_comb begin
        col_bits  = 4'd8 + {2'b00, col_sel};
        col_mask  = (COL_W'(1) << col_bits) - COL_W'(1);
        col       = waddr[COL_W-1:0] & col_mask;
        room      = (COL_W'(1) << col_bits) - col;
        above_col = waddr >> col_bits;
    end

    // Bank and row fields; the bank width is picked by NUM_BANKS.
    generate
        if (BANK_W >= 2) begin : g_four_bank
            always_comb begin
                bank = above_col[1:0];
                row  = ROW_W'(above_col >> 2);
            end
        end else begin : g_two_bank
            always_comb begin
                bank = {1'b0, above_col[0]};
                row  = ROW_W'(above_col >> 1);
            end
        end
    endgenerate
endmodule

// File: rtl/splt_ctrl.sv
// Splitter control: captures one application request, walks through it
// piece by piece, and closes it when the final piece is accepted.
// Assumes req_len >= 1 and that the request inputs stay stable while
// req_valid is held. The length width LW must be at least 12.
module splt_ctrl
    import splt_pkg::*;
#(
    parameter int AW = 25,
    parameter int LW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mem_width,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic [LW-1:0]    req_len,
    input  logic             req_wrap,
    input  logic             req_write,
    output logic             req_ack,
    input  logic [COL_W-1:0] room,
    input  logic             pc_ack,
    output logic             pc_valid,
    output logic [LW-1:0]    pc_len,
    output logic             pc_start,
    output logic             pc_last,
    output logic             pc_write,
    output logic             pc_wrap,
    output logic [AW-1:0]    cur_waddr,
    output logic             idle
);
    split_state_e  state_q;
    logic [LW-1:0] rem_q;
    logic          first_q;
    logic          wr_q;
    logic          wrap_q;
    logic [AW-1:0] word_addr;
    logic          fits;

    // Byte to word address conversion for the selected memory width.
    always_comb begin
        case (mem_width)
            2'b00:   word_addr = req_addr >> 2;
            2'b01:   word_addr = req_addr >> 1;
            default: word_addr = req_addr;
        endcase
    end

    // Length of the current piece and the markers offered with it.
    always_comb begin
        fits     = (rem_q <= LW'(room));
        pc_valid = (state_q == ST_SPLIT);
        pc_len   = wrap_q ? LW'(WRAP_LEN) : (fits ? rem_q : LW'(room));
        pc_last  = wrap_q | fits;
        pc_start = first_q;
        pc_write = wr_q;
        pc_wrap  = wrap_q;
        req_ack  = pc_valid & pc_ack & pc_last;
        idle     = (state_q == ST_IDLE) & ~req_valid;
    end

    // Request capture and advance to the next piece on each acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_waddr <= '0;
            rem_q     <= '0;
            first_q   <= 1'b0;
            wr_q      <= 1'b0;
            wrap_q    <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (req_valid) begin
                state_q   <= ST_SPLIT;
                cur_waddr <= word_addr;
                rem_q     <= req_len;
                first_q   <= 1'b1;
                wr_q      <= req_write;
                wrap_q    <= req_wrap;
            end
        end else if (pc_ack) begin
            if (pc_last) begin
                state_q <= ST_IDLE;
            end else begin
                cur_waddr <= cur_waddr + AW'(pc_len);
                rem_q     <= rem_q - pc_len;
                first_q   <= 1'b0;
            end
        end
    end

    // R9: an offered piece holds until it is accepted.
    assert_piece_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid && !pc_ack |=> pc_valid && $stable(pc_len) && $stable(pc_start)
                                && $stable(pc_last) && $stable(cur_waddr));

    // R10: completion returns the splitter to idle, so no second ack follows.
    assert_single_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !pc_valid && !req_ack);

    // R8: a piece following an accepted non-final piece is never marked first.
    assert_start_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid && pc_ack && !pc_last |=> pc_valid && !pc_start);

    // R11: idle never coexists with an offered piece.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !pc_valid);

    // R7: a wrapped piece is always the final one.
    assert_wrap_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid && pc_wrap |-> pc_last && pc_len == LW'(WRAP_LEN));

    // R12: a request seen while idle is offered, marked first, one cycle later.
    assert_first_piece_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_valid && req_valid |=> pc_valid && pc_start);
endmodule

// File: rtl/splt_req_splitter.sv
// Top of the request splitter: control plus address map. The map decodes
// the word address the control is currently working on, so bank, row and
// column follow the piece as it advances.
module splt_req_splitter
    import splt_pkg::*;
#(
    parameter int AW        = 25,
    parameter int LW        = 12,
    parameter int NUM_BANKS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    col_sel,
    input  logic [1:0]    mem_width,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          req_wrap,
    input  logic          req_write,
    output logic          req_ack,
    output logic          pc_valid,
    output logic [1:0]    pc_bank,
    output logic [11:0]   pc_row,
    output logic [11:0]   pc_col,
    output logic [LW-1:0] pc_len,
    output logic          pc_write,
    output logic          pc_wrap,
    output logic          pc_start,
    output logic          pc_last,
    input  logic          pc_ack,
    output logic          idle
);
    logic [AW-1:0]    cur_waddr;
    logic [COL_W-1:0] room;

    splt_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_width (mem_width),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_wrap  (req_wrap),
        .req_write (req_write),
        .req_ack   (req_ack),
        .room      (room),
        .pc_ack    (pc_ack),
        .pc_valid  (pc_valid),
        .pc_len    (pc_len),
        .pc_start  (pc_start),
        .pc_last   (pc_last),
        .pc_write  (pc_write),
        .pc_wrap   (pc_wrap),
        .cur_waddr (cur_waddr),
        .idle      (idle)
    );

    splt_addr_map #(.AW(AW), .NUM_BANKS(NUM_BANKS)) u_map (
        .waddr   (cur_waddr),
        .col_sel (col_sel),
        .bank    (pc_bank),
        .row     (pc_row),
        .col     (pc_col),
        .room    (room)
    );

    // R6: a non-wrapped piece never runs past the end of its column page.
    assert_in_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid && !pc_wrap |-> ({1'b0, pc_col} + 13'(pc_len)) <= (13'd1 << (8 + col_sel)));
endmodule

// File: tb/splt_req_splitter_tb.sv
module splt_req_splitter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  col_sel = 2'b00;
    logic [1:0]  mem_width = 2'b00;
    logic        req_valid = 1'b0;
    logic [24:0] req_addr = '0;
    logic [11:0] req_len = '0;
    logic        req_wrap = 1'b0;
    logic        req_write = 1'b0;
    logic        pc_ack = 1'b0;

    logic        req_ack, pc_valid, pc_write, pc_wrap, pc_start, pc_last, idle;
    logic [1:0]  pc_bank;
    logic [11:0] pc_row, pc_col, pc_len;
    logic        req_ack2, pc_valid2, pc_write2, pc_wrap2, pc_start2, pc_last2, idle2;
    logic [1:0]  pc_bank2;
    logic [11:0] pc_row2, pc_col2, pc_len2;

    int errors = 0;
    int checks = 0;
    int piece_no = 0;

    typedef struct {
        int bank; int row; int col; int len;
        int bank2; int row2;
        bit start; bit last; bit write; bit wrap;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    splt_req_splitter u_dut (
        .clk(clk), .rst_n(rst_n), .col_sel(col_sel), .mem_width(mem_width),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
        .req_wrap(req_wrap), .req_write(req_write), .req_ack(req_ack),
        .pc_valid(pc_valid), .pc_bank(pc_bank), .pc_row(pc_row), .pc_col(pc_col),
        .pc_len(pc_len), .pc_write(pc_write), .pc_wrap(pc_wrap),
        .pc_start(pc_start), .pc_last(pc_last), .pc_ack(pc_ack), .idle(idle)
    );

    splt_req_splitter #(.NUM_BANKS(2)) u_dut2 (
        .clk(clk), .rst_n(rst_n), .col_sel(col_sel), .mem_width(mem_width),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
        .req_wrap(req_wrap), .req_write(req_write), .req_ack(req_ack2),
        .pc_valid(pc_valid2), .pc_bank(pc_bank2), .pc_row(pc_row2), .pc_col(pc_col2),
        .pc_len(pc_len2), .pc_write(pc_write2), .pc_wrap(pc_wrap2),
        .pc_start(pc_start2), .pc_last(pc_last2), .pc_ack(pc_ack), .idle(idle2)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: computes the expected pieces, then presents the request.
    task automatic send(input int addr, input int len, input bit wrap, input bit wr,
                        input int sel, input int wd);
        int waddr = addr >> ((wd == 0) ? 2 : (wd == 1) ? 1 : 0);
        int rem = len;
        int cb = 8 + sel;
        bit first = 1'b1;
        bit done = 1'b0;
        while (!done) begin
            exp_t e;
            int col = waddr & ((1 << cb) - 1);
            int room = (1 << cb) - col;
            e.col   = col;
            e.bank  = (waddr >> cb) & 3;
            e.row   = (waddr >> (cb + 2)) & 12'hfff;
            e.bank2 = (waddr >> cb) & 1;
            e.row2  = (waddr >> (cb + 1)) & 12'hfff;
            e.len   = wrap ? 4 : ((rem < room) ? rem : room);
            e.last  = wrap || (rem <= room);
            e.start = first;
            e.write = wr;
            e.wrap  = wrap;
            q.push_back(e);
            done  = e.last;
            rem   = rem - e.len;
            waddr = (waddr + e.len) & 25'h1ffffff;
            first = 1'b0;
        end
        @(negedge clk);
        chk(idle == 1'b1, "R11 idle before request", int'(idle), 1);
        col_sel = 2'(sel); mem_width = 2'(wd);
        req_addr = 25'(addr); req_len = 12'(len); req_wrap = wrap; req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        #1;
        chk(pc_valid == 1'b1, "R12 first piece one cycle later", int'(pc_valid), 1);
        chk(idle == 1'b0, "R11 busy not idle", int'(idle), 0);
        forever begin
            @(posedge clk);
            if (req_ack) break;
        end
        #1 req_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(idle == 1'b1, "R11 idle after completion", int'(idle), 1);
        chk(pc_valid == 1'b0, "R10 no piece after completion", int'(pc_valid), 0);
        chk(q.size() == 0, "R6 all pieces delivered", q.size(), 0);
    endtask

    // Monitor: compares each offered piece with the scoreboard and acks it.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && pc_valid) begin
                exp_t e;
                int stall;
                if (q.size() == 0) begin
                    chk(1'b0, "R6 unexpected piece", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk(int'(pc_col) == e.col, "R2 column", int'(pc_col), e.col);
                    chk(int'(pc_bank) == e.bank, "R4 bank four-bank", int'(pc_bank), e.bank);
                    chk(int'(pc_bank2) == e.bank2, "R4 bank two-bank", int'(pc_bank2), e.bank2);
                    chk(int'(pc_row) == e.row, "R5 row four-bank", int'(pc_row), e.row);
                    chk(int'(pc_row2) == e.row2, "R5 row two-bank", int'(pc_row2), e.row2);
                    chk(int'(pc_len) == e.len, "R6 piece length", int'(pc_len), e.len);
                    chk(pc_start == e.start, "R8 start marker", int'(pc_start), int'(e.start));
                    chk(pc_last == e.last, "R8 last marker", int'(pc_last), int'(e.last));
                    chk(pc_write == e.write, "R8 write flag", int'(pc_write), int'(e.write));
                    chk(pc_wrap == e.wrap, "R7 wrap flag", int'(pc_wrap), int'(e.wrap));
                    stall = piece_no % 3;
                    for (int i = 0; i < stall; i++) begin
                        #1 chk(req_ack == 1'b0, "R10 no ack while stalled", int'(req_ack), 0);
                        @(negedge clk);
                        chk(pc_valid && int'(pc_len) == e.len && int'(pc_col) == e.col,
                            "R9 piece held", int'(pc_len), e.len);
                    end
                    pc_ack = 1'b1;
                    #1 chk(req_ack == e.last, "R10 ack on final piece", int'(req_ack), int'(e.last));
                    @(negedge clk);
                    pc_ack = 1'b0;
                    piece_no++;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(pc_valid == 1'b0, "R1 reset valid", int'(pc_valid), 0);
        chk(req_ack == 1'b0, "R1 reset ack", int'(req_ack), 0);
        chk(idle == 1'b1, "R1 reset idle", int'(idle), 1);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 R3: one piece inside a page, 16-bit memory, 8 column bits.
        send(25'h0000100, 16, 1'b0, 1'b1, 0, 1);
        // R6: page crossing into the next bank.
        send(25'h00001f0, 20, 1'b0, 1'b0, 0, 1);
        // R6: several pages, 8-bit memory.
        send(25'h0030080, 600, 1'b0, 1'b1, 0, 2);
        // R2 R3: 11 column bits, 32-bit memory, cut near the page end.
        send(25'h0001ff8, 5, 1'b0, 1'b0, 3, 0);
        // R7: wrapped transfer ignores the requested length.
        send(25'h0001234, 9, 1'b1, 1'b1, 1, 1);
        // R3 R5: single word, high address, 10 column bits.
        send(25'h1abcde4, 1, 1'b0, 1'b0, 2, 0);
        // R4 R5: crossing from bank 3 into the next row.
        send((5 << 10) | (3 << 8) | 8'hfe, 4, 1'b0, 1'b1, 0, 3);
        // R6: length exactly one full 9-bit page.
        send(25'h0004000, 512, 1'b0, 1'b0, 1, 2);
        // R6: remaining length equal to room left in the page.
        send(25'h00000f0, 16, 1'b0, 1'b1, 0, 2);
        // R7: wrapped read at the very end of an 11-bit page.
        send(25'h00007ff, 3, 1'b1, 1'b0, 3, 2);
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule